// File: doc/BRIEF.md
# Keypad Sequence Lock Controller

This block watches a two-key keypad and opens a door when the keys arrive in the order B, A, B. Its three inputs are a key-present flag and the two key lines. All three are already synchronous to the block clock. Every clock cycle in which the key-present flag is high counts as one key press. The block drives a one-cycle unlock pulse and a small binary count of the keys entered in the current attempt, for a display.

A mistaken key does not end the attempt at once. The controller moves to a separate failure track. That track keeps counting presses until three keys have been entered and then falls back to idle without opening. An observer therefore cannot tell from the display which key was wrong. The one exception is a wrong third key, which ends the attempt on that press.

Both outputs come from registers. They change only at a clock edge and depend only on the stored state, as in a Moore machine. A synchronous active-high reset returns the block to idle.

Top module: `seq_lock`

## Requirements
- R1: While reset is high at a clock edge, the controller goes to idle; after that edge `unlock` is 0 and `pressCount` is 0.
- R2: Inputs are read as {keyValid,keyA,keyB}. 110 is key A and 101 is key B. Any other pattern with keyValid=1 is a wrong key. keyValid=0 means no key, whatever keyA and keyB carry.
- R3: Keys B, A, B in that order, starting from idle, raise `unlock` for exactly one cycle, beginning the cycle after the edge that takes the third key; `pressCount` shows 1, 2, 3 after the three keys.
- R4: `pressCount` only takes the values 0 to 3, and all its bits above bit 1 are always 0.
- R5: A cycle with no key changes neither output, in every state except the unlock state.
- R6: A wrong first key moves the count to 1. The next two key presses, of any kind, move it to 2 and then to 0. No unlock occurs.
- R7: After a correct first key, a wrong second key moves the count to 2, the next key press of any kind returns it to 0, and no unlock occurs.
- R8: After two correct keys, a wrong third key returns the count to 0 at once, with no unlock.
- R9: One cycle after the unlock pulse, the block is idle (count 0), whatever the input was during the pulse cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| keyValid | input | 1 | High in each cycle that carries a key press |
| keyA | input | 1 | Key A line |
| keyB | input | 1 | Key B line |
| unlock | output | 1 | One-cycle door release pulse |
| pressCount | output | DISP_W | Keys entered in the current attempt |

## Verification
The bench uses the default display width of four bits. With that width it can check R4 directly: the two upper count bits must stay at zero. From a fresh reset it drives every sequence of four symbols drawn from five patterns: A, B, two wrong-key patterns, and a no-key pattern with both key lines high. That covers every branch of both the success track and the failure track, including the case where the key lines are set while keyValid is low. After each step the outputs are compared with a transition model kept in the bench. Directed runs add idle gaps between correct keys and hold a key down during the unlock cycle.

// File: rtl/seq_lock_pkg.sv
package seq_lock_pkg;

  // State codes are fixed; the display value follows from the state.
  typedef enum logic [2:0] {
    ST_IDLE = 3'b000,
    ST_BAD1 = 3'b001,
    ST_OK1  = 3'b010,
    ST_BAD2 = 3'b011,
    ST_OK2  = 3'b100,
    ST_OPEN = 3'b111
  } lockState_t;

  typedef enum logic [1:0] {
    KEY_NONE  = 2'd0,
    KEY_A     = 2'd1,
    KEY_B     = 2'd2,
    KEY_WRONG = 2'd3
  } keyClass_t;

  // Strobes from control to datapath, applied on the next edge.
  typedef struct packed {
    logic clr;   // count back to zero
    logic inc;   // one more key in this attempt
    logic fire;  // raise the unlock pulse
  } lockStrobe_t;

  // Number of presses shown for a state.
  function automatic logic [1:0] stateCount(lockState_t s);
    case (s)
      ST_OK1, ST_BAD1: stateCount = 2'd1;
      ST_OK2, ST_BAD2: stateCount = 2'd2;
      ST_OPEN:         stateCount = 2'd3;
      default:         stateCount = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/seq_lock_keydec.sv
module seq_lock_keydec
  import seq_lock_pkg::*;
(
  input  logic      keyValid,
  input  logic      keyA,
  input  logic      keyB,
  output keyClass_t keyClass
);

  always_comb begin
    if (!keyValid)            keyClass = KEY_NONE;
    else if (keyA && !keyB)   keyClass = KEY_A;
    else if (!keyA && keyB)   keyClass = KEY_B;
    else                      keyClass = KEY_WRONG;
  end

endmodule

// File: rtl/seq_lock_ctrl.sv
module seq_lock_ctrl
  import seq_lock_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  keyClass_t   keyClass,
  output lockStrobe_t strobe,
  output lockState_t  stateOut
);

  lockState_t state, nextState;

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE: case (keyClass)
        KEY_NONE: nextState = ST_IDLE;
        KEY_B:    nextState = ST_OK1;
        default:  nextState = ST_BAD1;
      endcase
      ST_OK1: case (keyClass)
        KEY_NONE: nextState = ST_OK1;
        KEY_A:    nextState = ST_OK2;
        default:  nextState = ST_BAD2;
      endcase
      ST_OK2: case (keyClass)
        KEY_NONE: nextState = ST_OK2;
        KEY_B:    nextState = ST_OPEN;
        default:  nextState = ST_IDLE;
      endcase
      ST_OPEN: nextState = ST_IDLE;
      ST_BAD1: nextState = (keyClass == KEY_NONE) ? ST_BAD1 : ST_BAD2;
      ST_BAD2: nextState = (keyClass == KEY_NONE) ? ST_BAD2 : ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.fire = (nextState == ST_OPEN);
    strobe.clr  = (nextState == ST_IDLE);
    strobe.inc  = (nextState != state) && (nextState != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  assign stateOut = state;

  AST_OPEN_LEAVES: assert property (@(posedge clk) disable iff (rst)
    state == ST_OPEN |=> state == ST_IDLE);  // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (keyClass == KEY_NONE && state != ST_OPEN) |=> $stable(state));  // R5
  AST_BAD3_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OK2 && keyClass != KEY_NONE && keyClass != KEY_B)
      |=> state == ST_IDLE);  // R8

endmodule

// File: rtl/seq_lock_dp.sv
module seq_lock_dp
  import seq_lock_pkg::*;
#(
  parameter int DISP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  lockStrobe_t       strobe,
  output logic [DISP_W-1:0] pressCount,
  output logic              unlockPulse
);

  localparam logic [DISP_W-1:0] CNT_ONE = DISP_W'(1);
  localparam logic [DISP_W-1:0] CNT_TOP = DISP_W'(3);

  always_ff @(posedge clk) begin
    if (rst) begin
      pressCount  <= '0;
      unlockPulse <= 1'b0;
    end else begin
      unlockPulse <= strobe.fire;
      if (strobe.clr)      pressCount <= '0;
      else if (strobe.inc) pressCount <= pressCount + CNT_ONE;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    unlockPulse |=> !unlockPulse);  // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    pressCount <= CNT_TOP);  // R4
  AST_OPEN_AT_THREE: assert property (@(posedge clk) disable iff (rst)
    unlockPulse |-> pressCount == CNT_TOP);  // R3

endmodule

// File: rtl/seq_lock.sv
module seq_lock
  import seq_lock_pkg::*;
#(
  parameter int DISP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              keyValid,
  input  logic              keyA,
  input  logic              keyB,
  output logic              unlock,
  output logic [DISP_W-1:0] pressCount
);

  keyClass_t   keyClass;
  lockStrobe_t strobe;
  lockState_t  state;

  seq_lock_keydec u_keydec (
    .keyValid (keyValid),
    .keyA     (keyA),
    .keyB     (keyB),
    .keyClass (keyClass)
  );

  seq_lock_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .keyClass (keyClass),
    .strobe   (strobe),
    .stateOut (state)
  );

  seq_lock_dp #(.DISP_W(DISP_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .pressCount  (pressCount),
    .unlockPulse (unlock)
  );

  AST_COUNT_TRACKS: assert property (@(posedge clk) disable iff (rst)
    pressCount == DISP_W'(stateCount(state)));  // R4
  AST_UNLOCK_STATE: assert property (@(posedge clk) disable iff (rst)
    unlock == (state == ST_OPEN));  // R3

endmodule

// File: tb/seq_lock_test.sv
module seq_lock_test;

  logic clk = 1'b0;
  logic rst = 1'b0;
  logic keyValid = 1'b0, keyA = 1'b0, keyB = 1'b0;
  logic unlock;
  logic [3:0] pressCount;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // model states: 0 idle, 1 ok1, 2 ok2, 3 open, 4 bad1, 5 bad2
  int mState = 0;

  always #5 clk = ~clk;

  seq_lock #(.DISP_W(4)) uut (
    .clk(clk), .rst(rst), .keyValid(keyValid), .keyA(keyA), .keyB(keyB),
    .unlock(unlock), .pressCount(pressCount)
  );

  function automatic int keyKind(logic v, logic a, logic b);
    if (!v) return 0;            // none
    if (a && !b) return 1;       // A
    if (!a && b) return 2;       // B
    return 3;                    // wrong
  endfunction

  function automatic int modelNext(int s, int k);
    case (s)
      0: return (k == 0) ? 0 : (k == 2) ? 1 : 4;
      1: return (k == 0) ? 1 : (k == 1) ? 2 : 5;
      2: return (k == 0) ? 2 : (k == 2) ? 3 : 0;
      3: return 0;
      4: return (k == 0) ? 4 : 5;
      5: return (k == 0) ? 5 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic logic [3:0] modelCount(int s);
    case (s)
      1, 4: return 4'd1;
      2, 5: return 4'd2;
      3:    return 4'd3;
      default: return 4'd0;
    endcase
  endfunction

  task automatic check(string req, logic [3:0] expC, logic expU);
    checks++;
    if (pressCount !== expC || unlock !== expU) begin
      fails++;
      $display("FAIL %s: count=%0d unlock=%0b expected count=%0d unlock=%0b",
               req, pressCount, unlock, expC, expU);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; keyValid = 1'b0; keyA = 1'b0; keyB = 1'b0;
    @(posedge clk); #1;
    rst = 1'b0;
    mState = 0;
    check("R1", 4'd0, 1'b0);
  endtask

  // apply one input pattern for one cycle and advance the model
  task automatic step(logic v, logic a, logic b);
    @(negedge clk);
    keyValid = v; keyA = a; keyB = b;
    @(posedge clk); #1;
    mState = modelNext(mState, keyKind(v, a, b));
  endtask

  task automatic stepCheck(string req, logic v, logic a, logic b);
    step(v, a, b);
    check(req, modelCount(mState), mState == 3);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    doReset();

    // R3 R5: B,A,B with no-key gaps, key lines set during gaps (R2)
    stepCheck("R3", 1, 0, 1);
    stepCheck("R5", 0, 1, 1);
    stepCheck("R5", 0, 1, 0);
    stepCheck("R3", 1, 1, 0);
    stepCheck("R5", 0, 0, 1);
    stepCheck("R3", 1, 0, 1);
    if (unlock !== 1'b1) begin checks++; fails++; $display("FAIL R3: unlock=%0b expected 1", unlock); end
    else checks++;
    // R9: key held in the pulse cycle, still idle next
    stepCheck("R9", 1, 0, 1);
    if (pressCount !== 4'd0 || unlock !== 1'b0) begin
      checks++; fails++;
      $display("FAIL R9: count=%0d unlock=%0b expected 0/0", pressCount, unlock);
    end else checks++;

    // R7: wrong second key
    doReset();
    stepCheck("R7", 1, 0, 1);
    stepCheck("R7", 1, 1, 1);
    stepCheck("R7", 0, 0, 0);
    stepCheck("R7", 1, 1, 0);

    // R8: wrong third key
    doReset();
    stepCheck("R8", 1, 0, 1);
    stepCheck("R8", 1, 1, 0);
    stepCheck("R8", 1, 0, 0);
    if (pressCount !== 4'd0) begin checks++; fails++; $display("FAIL R8: count=%0d expected 0", pressCount); end
    else checks++;

    // R6: wrong first key then two good-looking keys
    doReset();
    stepCheck("R6", 1, 1, 0);
    stepCheck("R6", 1, 0, 1);
    stepCheck("R6", 1, 1, 0);

    // sweep: every 4-symbol sequence over five patterns
    for (int seq = 0; seq < 625; seq++) begin
      int code = seq;
      doReset();
      for (int i = 0; i < 4; i++) begin
        int sym = code % 5;
        int prev = mState;
        string tag;
        code = code / 5;
        case (sym)
          0: step(0, 1, 1);   // R2: no key despite lines
          1: step(1, 1, 0);
          2: step(1, 0, 1);
          3: step(1, 0, 0);
          default: step(1, 1, 1);
        endcase
        if (prev == 3)                      tag = "R9";
        else if (sym == 0)                  tag = "R5";
        else if (mState == 3)               tag = "R3";
        else if (prev == 2 && mState == 0)  tag = "R8";
        else if (prev >= 4 || mState == 4)  tag = "R6";
        else if (mState == 5)               tag = "R7";
        else                                tag = "R2";
        check(tag, modelCount(mState), mState == 3);
        if (pressCount[3:2] !== 2'b00) begin
          fails++;
          $display("FAIL R4: upper bits=%0b expected 00", pressCount[3:2]);
        end
        checks++;
      end
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule